// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit

This block is the multiply/divide coprocessor beside a 32-bit integer core. It keeps a 64-bit result in two 32-bit halves, HI and LO. It takes a 4-bit operation code. The upper two code bits come from instruction bits 4-3 and the lower two from instruction bits 1-0. A `start` strobe launches the coded operation on the two operands. Multiply and divide run one bit per cycle for 32 cycles, and `busy` is high while they run. Moves to and from HI/LO take a single cycle.

The controller is a three-state machine. ST_IDLE accepts a strobe and decodes the code. The transition "launch multiply" (codes 1100/1101) goes to ST_MULT. The transition "launch divide" (codes 1110/1111) goes to ST_DIV. The transition "final step" returns either running state to ST_IDLE on the 32nd iteration, and HI/LO are written on that edge. Every other code is served inside ST_IDLE.

Signed operations work on operand magnitudes. A sign correction is applied when the result is stored.

Top module: `muldiv_unit`

## Requirements
- R1: After reset `busy` is 0, `rd_data` is 0, and HI and LO both read back as 0.
- R2: A strobe with code 0000, or with any code whose top bit is 0, changes nothing: `busy`, `rd_data`, HI and LO all keep their values.
- R3: Code 1001 loads `opnd_a` into HI, and code 1011 loads `opnd_a` into LO, on the strobe's clock edge.
- R4: Code 1000 places HI on `rd_data`, and code 1010 places LO on `rd_data`, from the edge after the strobe. `rd_data` holds its value until the next accepted read.
- R5: Code 1101 forms the unsigned 64-bit product of the operands: the upper 32 bits go to HI and the lower 32 bits to LO.
- R6: Code 1100 forms the two's-complement signed 64-bit product, with the same HI/LO split as R5.
- R7: Code 1111 divides `opnd_a` by `opnd_b` unsigned, leaving the quotient in LO and the remainder in HI.
- R8: Code 1110 divides signed. The quotient truncates toward zero and the remainder takes the dividend's sign. The case -2^31 / -1 gives quotient 0x80000000 and remainder 0.
- R9: `busy` rises on the edge that accepts a multiply or divide. It stays high for exactly 32 cycles. The result is readable as soon as `busy` is low.
- R10: Any strobe while `busy` is high is ignored, and `rd_data` does not change while `busy` is high.
- R11: Division by zero completes in the normal 32 busy cycles and leaves the unit ready for new operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Operation strobe, one cycle |
| func | input | 4 | Operation code {instr[4:3], instr[1:0]} |
| opnd_a | input | 32 | First operand: multiplicand, dividend, or HI/LO write data |
| opnd_b | input | 32 | Second operand: multiplier or divisor |
| rd_data | output | 32 | Last HI or LO value read |
| busy | output | 1 | Multiply or divide in progress |

## Verification
The multiply is tried with small values, with all-ones operands, and with every sign pairing including 0x80000000 squared. These separate a wrong HI/LO split, a lost carry out of the top add, and a faulty negation of the magnitudes. The divide is tried with the four dividend/divisor sign pairings, with -2^31 / -1, and with a zero divisor. These separate quotient sign errors from remainder sign errors and check that the last iteration still ends the run. Writes and reads issued in the middle of a run show whether the hold-off is obeyed. A reference model checks `busy` and `rd_data` on every cycle, which also pins the exact 32-cycle length.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    typedef enum logic [3:0] {
        FN_NOP   = 4'b0000,
        FN_RD_HI = 4'b1000,
        FN_WR_HI = 4'b1001,
        FN_RD_LO = 4'b1010,
        FN_WR_LO = 4'b1011,
        FN_MUL_S = 4'b1100,
        FN_MUL_U = 4'b1101,
        FN_DIV_S = 4'b1110,
        FN_DIV_U = 4'b1111
    } fn_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MULT = 2'd1,
        ST_DIV  = 2'd2
    } st_e;

endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
    import muldiv_pkg::*;
#(
    parameter int ITERS = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [3:0] func,
    output st_e        state,
    output logic       idle,
    output logic       launch_mul,
    output logic       launch_div,
    output logic       last
);
    localparam int CNT_W = (ITERS > 1) ? $clog2(ITERS) : 1;

    st_e              state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // state register and iteration counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE)
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // outputs and transitions
    always_comb begin
        idle       = (state_q == ST_IDLE);
        launch_mul = idle && start && (func[3:1] == 3'b110);
        launch_div = idle && start && (func[3:1] == 3'b111);
        last       = !idle && (cnt_q == CNT_W'(ITERS - 1));
        state      = state_q;
        state_d    = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (launch_mul)      state_d = ST_MULT;
                else if (launch_div) state_d = ST_DIV;
            end
            ST_MULT, ST_DIV: begin
                if (last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/muldiv_mul_step.sv
module muldiv_mul_step #(
    parameter int W = 32
) (
    input  logic [2*W-1:0] prod,
    input  logic [W-1:0]   mcand,
    output logic [2*W-1:0] nxt
);
    logic [W:0] sum;

    always_comb begin
        sum = {1'b0, prod[2*W-1:W]} + {1'b0, (prod[0] ? mcand : {W{1'b0}})};
        nxt = {sum, prod[W-1:1]};
    end
endmodule

// File: rtl/muldiv_div_step.sv
module muldiv_div_step #(
    parameter int W = 32
) (
    input  logic [2*W-1:0] rq,
    input  logic [W-1:0]   dvsr,
    output logic [2*W-1:0] nxt
);
    logic [W:0] shifted;
    logic [W:0] diff;
    logic       fits;

    always_comb begin
        shifted = {rq[2*W-1:W], rq[W-1]};
        diff    = shifted - {1'b0, dvsr};
        fits    = !diff[W];
        nxt     = {(fits ? diff[W-1:0] : shifted[W-1:0]), rq[W-2:0], fits};
    end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
    import muldiv_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [3:0]       func,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic [WIDTH-1:0] rd_data,
    output logic             busy
);
    localparam int ITERS = WIDTH;
    localparam int DW    = 2 * WIDTH;

    st_e              state;
    logic             idle, launch_mul, launch_div, last;
    logic [WIDTH-1:0] hi_q, lo_q, rd_q, opm_q;
    logic [DW-1:0]    work_q, mul_nxt, div_nxt, prod_fix;
    logic             neg_lo_q, neg_hi_q;
    logic             sgn, sa, sb;
    logic [WIDTH-1:0] mag_a, mag_b, quo_fix, rem_fix;

    muldiv_ctrl #(.ITERS(ITERS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .func       (func),
        .state      (state),
        .idle       (idle),
        .launch_mul (launch_mul),
        .launch_div (launch_div),
        .last       (last)
    );

    muldiv_mul_step #(.W(WIDTH)) u_mul (
        .prod  (work_q),
        .mcand (opm_q),
        .nxt   (mul_nxt)
    );

    muldiv_div_step #(.W(WIDTH)) u_div (
        .rq   (work_q),
        .dvsr (opm_q),
        .nxt  (div_nxt)
    );

    always_comb begin
        sgn      = !func[0];
        sa       = sgn && opnd_a[WIDTH-1];
        sb       = sgn && opnd_b[WIDTH-1];
        mag_a    = sa ? -opnd_a : opnd_a;
        mag_b    = sb ? -opnd_b : opnd_b;
        prod_fix = neg_lo_q ? -mul_nxt : mul_nxt;
        quo_fix  = neg_lo_q ? -div_nxt[WIDTH-1:0] : div_nxt[WIDTH-1:0];
        rem_fix  = neg_hi_q ? -div_nxt[DW-1:WIDTH] : div_nxt[DW-1:WIDTH];
        busy     = !idle;
        rd_data  = rd_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q     <= '0;
            lo_q     <= '0;
            rd_q     <= '0;
            opm_q    <= '0;
            work_q   <= '0;
            neg_lo_q <= 1'b0;
            neg_hi_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        case (func)
                            FN_RD_HI: rd_q <= hi_q;
                            FN_RD_LO: rd_q <= lo_q;
                            FN_WR_HI: hi_q <= opnd_a;
                            FN_WR_LO: lo_q <= opnd_a;
                            FN_MUL_S, FN_MUL_U: begin
                                work_q   <= {{WIDTH{1'b0}}, mag_b};
                                opm_q    <= mag_a;
                                neg_lo_q <= sa ^ sb;
                                neg_hi_q <= sa ^ sb;
                            end
                            FN_DIV_S, FN_DIV_U: begin
                                work_q   <= {{WIDTH{1'b0}}, mag_a};
                                opm_q    <= mag_b;
                                neg_lo_q <= sa ^ sb;
                                neg_hi_q <= sa;
                            end
                            default: ;
                        endcase
                    end
                end
                ST_MULT: begin
                    work_q <= mul_nxt;
                    if (last) begin
                        hi_q <= prod_fix[DW-1:WIDTH];
                        lo_q <= prod_fix[WIDTH-1:0];
                    end
                end
                ST_DIV: begin
                    work_q <= div_nxt;
                    if (last) begin
                        hi_q <= rem_fix;
                        lo_q <= quo_fix;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk #(
    parameter int WIDTH = 32,
    parameter int ITERS = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [3:0]       func,
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] rd_data,
    input logic             busy,
    input logic [WIDTH-1:0] hi
);
    logic [15:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    // R9
    launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && func[3:2] == 2'b11) |=> busy);

    // R9
    run_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == 16'(ITERS)));

    // R9
    run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_len < 16'(ITERS)));

    // R10
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(rd_data));

    // R2
    nop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && func == 4'b0000) |=> (!busy && $stable(rd_data) && $stable(hi)));

    // R3
    hi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && func == 4'b1001) |=> (hi == $past(opnd_a)));
endmodule

bind muldiv_unit muldiv_unit_chk #(.WIDTH(WIDTH), .ITERS(ITERS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .func    (func),
    .opnd_a  (opnd_a),
    .rd_data (rd_data),
    .busy    (busy),
    .hi      (hi_q)
);

// File: tb/muldiv_unit_bench.sv
module muldiv_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  func = 4'b0000;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [31:0] rd_data;
    logic        busy;

    int checks = 0;
    int bad = 0;
    string cur_req = "R1";

    // reference model state
    logic [31:0] m_hi = '0, m_lo = '0, m_rd = '0, p_hi = '0, p_lo = '0;
    bit          m_hi_ok = 1, m_lo_ok = 1, m_rd_ok = 1, p_ok = 1;
    int          m_busy = 0;

    always #10 clk = ~clk;

    muldiv_unit u_muldiv_unit (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .func    (func),
        .opnd_a  (opnd_a),
        .opnd_b  (opnd_b),
        .rd_data (rd_data),
        .busy    (busy)
    );

    always @(posedge clk) begin
        if (rst_n) begin
            if (m_busy > 0) begin
                m_busy = m_busy - 1;
                if (m_busy == 0) begin
                    m_hi = p_hi; m_lo = p_lo; m_hi_ok = p_ok; m_lo_ok = p_ok;
                end
            end else if (start) begin
                logic [63:0] p;
                longint sa, sb;
                case (func)
                    4'b1000: begin m_rd = m_hi; m_rd_ok = m_hi_ok; end
                    4'b1010: begin m_rd = m_lo; m_rd_ok = m_lo_ok; end
                    4'b1001: begin m_hi = opnd_a; m_hi_ok = 1; end
                    4'b1011: begin m_lo = opnd_a; m_lo_ok = 1; end
                    4'b1101: begin
                        p = {32'b0, opnd_a} * {32'b0, opnd_b};
                        p_hi = p[63:32]; p_lo = p[31:0]; p_ok = 1; m_busy = 32;
                    end
                    4'b1100: begin
                        p = 64'(longint'($signed(opnd_a)) * longint'($signed(opnd_b)));
                        p_hi = p[63:32]; p_lo = p[31:0]; p_ok = 1; m_busy = 32;
                    end
                    4'b1111: begin
                        p_ok = (opnd_b != 0);
                        if (p_ok) begin p_lo = opnd_a / opnd_b; p_hi = opnd_a % opnd_b; end
                        m_busy = 32;
                    end
                    4'b1110: begin
                        sa = longint'($signed(opnd_a)); sb = longint'($signed(opnd_b));
                        p_ok = (opnd_b != 0);
                        if (p_ok) begin p_lo = 32'(sa / sb); p_hi = 32'(sa % sb); end
                        m_busy = 32;
                    end
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (busy !== (m_busy > 0)) begin
                bad++;
                $display("FAIL %s busy: actual=%b expected=%b", cur_req, busy, (m_busy > 0));
            end
            if (m_rd_ok) begin
                checks++;
                if (rd_data !== m_rd) begin
                    bad++;
                    $display("FAIL %s rd_data: actual=%h expected=%h", cur_req, rd_data, m_rd);
                end
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] f, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        start = 1'b1; func = f; opnd_a = a; opnd_b = b;
        @(negedge clk);
        start = 1'b0; func = 4'b0000;
    endtask

    task automatic settle();
        while (busy) @(negedge clk);
    endtask

    task automatic read_both();
        issue(4'b1000, '0, '0);
        issue(4'b1010, '0, '0);
    endtask

    task automatic run_op(input string req, input logic [3:0] f, input logic [31:0] a, input logic [31:0] b);
        cur_req = req;
        issue(f, a, b);
        settle();
        read_both();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL R9 watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", {31'b0, busy}, 32'd0);
        chk("R1", rd_data, 32'd0);
        rst_n = 1'b1;
        cur_req = "R1";
        read_both();
        chk("R1", rd_data, 32'd0);

        cur_req = "R3";
        issue(4'b1001, 32'h1234_5678, '0);
        issue(4'b1011, 32'h9abc_def0, '0);
        cur_req = "R4";
        issue(4'b1000, '0, '0);
        chk("R4", rd_data, 32'h1234_5678);
        issue(4'b1010, '0, '0);
        chk("R4", rd_data, 32'h9abc_def0);

        cur_req = "R2";
        issue(4'b0000, 32'hffff_ffff, 32'h1);
        issue(4'b0101, 32'hffff_ffff, 32'h1);
        chk("R2", rd_data, 32'h9abc_def0);
        read_both();

        run_op("R5", 4'b1101, 32'd7, 32'd6);
        run_op("R5", 4'b1101, 32'hffff_ffff, 32'hffff_ffff);
        chk("R5", rd_data, 32'h0000_0001);
        run_op("R6", 4'b1100, 32'hffff_fffd, 32'd5);
        run_op("R6", 4'b1100, 32'h8000_0000, 32'h8000_0000);
        run_op("R6", 4'b1100, 32'hffff_fff9, 32'hffff_fffa);
        run_op("R6", 4'b1100, 32'h0001_0003, 32'hfff0_0001);

        run_op("R7", 4'b1111, 32'd100, 32'd7);
        chk("R7", rd_data, 32'd14);
        run_op("R7", 4'b1111, 32'hffff_ffff, 32'd3);
        run_op("R7", 4'b1111, 32'd3, 32'd10);
        run_op("R8", 4'b1110, 32'd7, 32'hffff_fffe);
        run_op("R8", 4'b1110, 32'hffff_fff9, 32'd2);
        chk("R8", rd_data, 32'hffff_fffd);
        run_op("R8", 4'b1110, 32'hffff_fff9, 32'hffff_fffe);
        run_op("R8", 4'b1110, 32'h8000_0000, 32'hffff_ffff);
        chk("R8", rd_data, 32'h8000_0000);

        cur_req = "R9";
        issue(4'b1101, 32'd3, 32'd3);
        begin
            int n = 1;
            while (busy) begin n++; @(negedge clk); end
            chk("R9", 32'(n - 1), 32'd32);
        end
        issue(4'b1010, '0, '0);
        chk("R9", rd_data, 32'd9);

        cur_req = "R10";
        issue(4'b1101, 32'd11, 32'd13);
        issue(4'b1001, 32'hdead_beef, '0);
        issue(4'b1000, '0, '0);
        issue(4'b1111, 32'd1, 32'd1);
        settle();
        issue(4'b1010, '0, '0);
        chk("R10", rd_data, 32'd143);
        issue(4'b1000, '0, '0);
        chk("R10", rd_data, 32'd0);

        cur_req = "R11";
        issue(4'b1111, 32'd55, 32'd0);
        begin
            int n = 1;
            while (busy) begin n++; @(negedge clk); end
            chk("R11", 32'(n - 1), 32'd32);
        end
        issue(4'b1110, 32'hffff_0000, 32'd0);
        settle();
        run_op("R11", 4'b1101, 32'd21, 32'd2);
        chk("R11", rd_data, 32'd42);

        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule